// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block handles the address phase of an I2C target. After a START it shifts in the first byte, and in 10-bit mode the second byte as well. It checks them against a programmed own address and, when that is enabled, against the general call address. For a matching byte it asks the pad logic to pull SDA low for the acknowledge clock. It also records the transfer direction that the master requested.

A separate bus monitor supplies the inputs as single-cycle pulses in the core clock domain:

- START or repeated START.
- STOP.
- SCL rising edge.
- SCL falling edge.
- The SDA level, valid while a rising-edge pulse is present.

All pins are plain control and status. No stream passes the block edge, so nothing can be held back and there is no valid/ready handshake. The byte passed from the shifter to the controller inside the block is a one-cycle valid strobe with no back-pressure: the controller always accepts it in the cycle it appears. The data phase belongs to another block. This one only reports the match through its flags.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: After reset, addr_as_slave, addr_by_gc, slave_rw and ack_drive are all 0.
- R2: In 7-bit mode (ten_bit_mode=0), bits are taken MSB first, one per scl_rise pulse. If the first byte after START is {own_addr[6:0], rw}, addr_as_slave is set on the clock after the eighth scl_rise pulse, and slave_rw takes rw (1 = master reads, 0 = master writes).
- R3: For a matching byte, ack_drive goes to 1 on the clock after the first scl_fall pulse that follows bit 8. It returns to 0 on the clock after the scl_fall pulse that follows the ninth scl_rise pulse.
- R4: If the first byte matches nothing, ack_drive stays 0 and no flag is set. Every later byte is ignored until the next START.
- R5: With gc_enable=1, a first byte of 8'h00 sets addr_by_gc and is acknowledged, and addr_as_slave stays 0. With gc_enable=0, 8'h00 is ignored. 8'h01 is never treated as a general call.
- R6: In 10-bit mode the first byte must be {5'b11110, own_addr[9:8], rw}. That byte is acknowledged and rw is stored in slave_rw. The second byte must equal own_addr[7:0]; it is then acknowledged and addr_as_slave is set. A second byte that does not match gets no acknowledge and sets no flag.
- R7: In 10-bit mode a byte equal to {own_addr[6:0], rw} is ignored. A general call still matches when gc_enable=1.
- R8: A STOP or a repeated START clears addr_as_slave, addr_by_gc and ack_drive on the next clock. slave_rw keeps its last value.
- R9: A START in the middle of a byte restarts bit counting from the first bit. SCL pulses seen before any START change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | START or repeated START seen (pulse) |
| stop_evt | input | 1 | STOP seen (pulse) |
| scl_rise | input | 1 | SCL rising edge (pulse) |
| scl_fall | input | 1 | SCL falling edge (pulse) |
| sda_in | input | 1 | SDA level, valid while scl_rise is high |
| own_addr | input | ADDR_W | Own target address; the low 7 bits are used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 allows the general call to be answered |
| addr_as_slave | output | 1 | Own address matched |
| addr_by_gc | output | 1 | General call matched |
| slave_rw | output | 1 | Direction requested by the master |
| ack_drive | output | 1 | Request to hold SDA low |

## Verification
The bench builds the block with its defaults: BYTE_W=8 and ADDR_W=10. This means the own address in 7-bit mode is a slice of the 10-bit address. That lets the same own_addr value be matched in both modes, which is how R7 shows a valid 7-bit match being ignored once 10-bit mode is on. With the 8-bit byte width, the 10-bit header has exactly two upper-address bits. So the header byte 8'hF2 followed by 8'hD5 walks the full two-byte acknowledge sequence for own_addr 10'h1D5.

// File: rtl/i2c_sam_pkg.sv
package i2c_sam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_HDR,
    ST_RX_LOW,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_ACK_END,
    ST_DONE
  } sam_state_e;

  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_SEVEN,
    HIT_GC,
    HIT_HDR
  } hdr_hit_e;
endpackage

// File: rtl/i2c_sam_shifter.sv
module i2c_sam_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              capture_en,
  input  logic              scl_rise,
  input  logic              sda_in,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              take;
  logic              at_last;

  assign take       = capture_en & scl_rise;
  assign at_last    = (bit_cnt == LAST_BIT);
  assign byte_data  = {shreg, sda_in};
  assign byte_valid = take & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (restart) begin
      bit_cnt <= '0;
    end else if (take) begin
      shreg   <= byte_data[BYTE_W-2:0];
      bit_cnt <= at_last ? '0 : bit_cnt + 1'b1;
    end
  end

  // R2: bit counter never passes the byte width
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(BYTE_W));

  // R9: a complete byte leaves the counter back at the first bit
  p_cnt_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> bit_cnt == '0);
endmodule

// File: rtl/i2c_sam_decode.sv
module i2c_sam_decode
  import i2c_sam_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit_mode,
  input  logic              gc_enable,
  output hdr_hit_e          hdr_hit,
  output logic              low_hit
);
  localparam int unsigned HI_W  = ADDR_W - BYTE_W;
  localparam int unsigned TAG_W = BYTE_W - 1 - HI_W;
  localparam logic [TAG_W-1:0] TEN_TAG = {{(TAG_W-1){1'b1}}, 1'b0};

  logic gc_hit;
  logic seven_hit;
  logic hdr_ok;

  always_comb begin
    gc_hit    = gc_enable && (byte_data == '0);
    seven_hit = !ten_bit_mode &&
                (byte_data[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
    hdr_ok    = ten_bit_mode &&
                (byte_data[BYTE_W-1 -: TAG_W] == TEN_TAG) &&
                (byte_data[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
    if (gc_hit)         hdr_hit = HIT_GC;
    else if (seven_hit) hdr_hit = HIT_SEVEN;
    else if (hdr_ok)    hdr_hit = HIT_HDR;
    else                hdr_hit = HIT_NONE;
    low_hit = (byte_data == own_addr[BYTE_W-1:0]);
  end
endmodule

// File: rtl/i2c_sam_ctrl.sv
module i2c_sam_ctrl
  import i2c_sam_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_evt,
  input  logic     stop_evt,
  input  logic     scl_rise,
  input  logic     scl_fall,
  input  logic     byte_valid,
  input  logic     rw_bit,
  input  hdr_hit_e hdr_hit,
  input  logic     low_hit,
  output logic     capture_en,
  output logic     restart,
  output logic     addr_as_slave,
  output logic     addr_by_gc,
  output logic     slave_rw,
  output logic     ack_drive
);
  sam_state_e state;
  sam_state_e after_ack;

  assign restart    = start_evt | stop_evt;
  assign capture_en = (state == ST_RX_HDR) || (state == ST_RX_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      after_ack     <= ST_IDLE;
      addr_as_slave <= 1'b0;
      addr_by_gc    <= 1'b0;
      slave_rw      <= 1'b0;
      ack_drive     <= 1'b0;
    end else if (stop_evt) begin
      state         <= ST_IDLE;
      addr_as_slave <= 1'b0;
      addr_by_gc    <= 1'b0;
      ack_drive     <= 1'b0;
    end else if (start_evt) begin
      state         <= ST_RX_HDR;
      addr_as_slave <= 1'b0;
      addr_by_gc    <= 1'b0;
      ack_drive     <= 1'b0;
    end else begin
      unique case (state)
        ST_RX_HDR: if (byte_valid) begin
          unique case (hdr_hit)
            HIT_SEVEN: begin
              addr_as_slave <= 1'b1;
              slave_rw      <= rw_bit;
              after_ack     <= ST_DONE;
              state         <= ST_ACK_WAIT;
            end
            HIT_GC: begin
              addr_by_gc <= 1'b1;
              slave_rw   <= rw_bit;
              after_ack  <= ST_DONE;
              state      <= ST_ACK_WAIT;
            end
            HIT_HDR: begin
              slave_rw  <= rw_bit;
              after_ack <= ST_RX_LOW;
              state     <= ST_ACK_WAIT;
            end
            default: state <= ST_IDLE;
          endcase
        end
        ST_RX_LOW: if (byte_valid) begin
          if (low_hit) begin
            addr_as_slave <= 1'b1;
            after_ack     <= ST_DONE;
            state         <= ST_ACK_WAIT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          ack_drive <= 1'b1;
          state     <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_rise) state <= ST_ACK_END;
        ST_ACK_END: if (scl_fall) begin
          ack_drive <= 1'b0;
          state     <= after_ack;
        end
        default: state <= state;
      endcase
    end
  end

  // R3: acknowledge starts only on an SCL falling edge
  p_ack_rise_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> $past(scl_fall));

  // R3: acknowledge ends on an SCL falling edge or a bus condition
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_drive) |-> $past(scl_fall || start_evt || stop_evt));

  // R8: STOP clears the match flags and the acknowledge
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !addr_as_slave && !addr_by_gc && !ack_drive);

  // R8: repeated START clears the match flags
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !addr_as_slave && !addr_by_gc);

  // R5: general call and own-address match never coexist
  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_as_slave && addr_by_gc));

  // R2: a new own-address match only follows a completed byte
  p_match_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_as_slave) |-> $past(byte_valid));
endmodule

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match
  import i2c_sam_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit_mode,
  input  logic              gc_enable,
  output logic              addr_as_slave,
  output logic              addr_by_gc,
  output logic              slave_rw,
  output logic              ack_drive
);
  logic              restart;
  logic              capture_en;
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;
  hdr_hit_e          hdr_hit;
  logic              low_hit;

  i2c_sam_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .capture_en (capture_en),
    .scl_rise   (scl_rise),
    .sda_in     (sda_in),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  i2c_sam_decode #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dec (
    .byte_data    (byte_data),
    .own_addr     (own_addr),
    .ten_bit_mode (ten_bit_mode),
    .gc_enable    (gc_enable),
    .hdr_hit      (hdr_hit),
    .low_hit      (low_hit)
  );

  i2c_sam_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .byte_valid    (byte_valid),
    .rw_bit        (byte_data[0]),
    .hdr_hit       (hdr_hit),
    .low_hit       (low_hit),
    .capture_en    (capture_en),
    .restart       (restart),
    .addr_as_slave (addr_as_slave),
    .addr_by_gc    (addr_by_gc),
    .slave_rw      (slave_rw),
    .ack_drive     (ack_drive)
  );
endmodule

// File: tb/i2c_slave_addr_match_tb.sv
module i2c_slave_addr_match_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_evt = 1'b0, stop_evt = 1'b0;
  logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b0;
  logic [9:0] own_addr = 10'h055;
  logic       ten_bit_mode = 1'b0, gc_enable = 1'b0;
  logic       addr_as_slave, addr_by_gc, slave_rw, ack_drive;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .own_addr(own_addr), .ten_bit_mode(ten_bit_mode), .gc_enable(gc_enable),
    .addr_as_slave(addr_as_slave), .addr_by_gc(addr_by_gc),
    .slave_rw(slave_rw), .ack_drive(ack_drive)
  );

  // Behavioural reference: phase 0 idle, 1 first byte, 2 second byte,
  // 3 waiting for ack fall, 4 ack low, 5 ack ending, 6 addressed
  int         m_phase = 0;
  int         m_next = 0;
  logic [7:0] m_bits[$];
  logic       e_aas = 0, e_gc = 0, e_rw = 0, e_ack = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_bits.delete();
      e_aas = 0; e_gc = 0; e_rw = 0; e_ack = 0;
    end else if (stop_evt || start_evt) begin
      m_phase = stop_evt ? 0 : 1;
      m_bits.delete();
      e_aas = 0; e_gc = 0; e_ack = 0;
    end else if ((m_phase == 1 || m_phase == 2) && scl_rise) begin
      m_bits.push_back({7'd0, sda_in});
      if (m_bits.size() == 8) begin
        logic [7:0] b;
        b = '0;
        foreach (m_bits[i]) b = {b[6:0], m_bits[i][0]};
        m_bits.delete();
        if (m_phase == 1) begin
          if (gc_enable && b == 8'h00) begin
            e_gc = 1; e_rw = 0; m_next = 6; m_phase = 3;
          end else if (!ten_bit_mode && b[7:1] == own_addr[6:0]) begin
            e_aas = 1; e_rw = b[0]; m_next = 6; m_phase = 3;
          end else if (ten_bit_mode && b[7:3] == 5'b11110 && b[2:1] == own_addr[9:8]) begin
            e_rw = b[0]; m_next = 2; m_phase = 3;
          end else m_phase = 0;
        end else begin
          if (b == own_addr[7:0]) begin
            e_aas = 1; m_next = 6; m_phase = 3;
          end else m_phase = 0;
        end
      end
    end else if (m_phase == 3 && scl_fall) begin
      e_ack = 1; m_phase = 4;
    end else if (m_phase == 4 && scl_rise) begin
      m_phase = 5;
    end else if (m_phase == 5 && scl_fall) begin
      e_ack = 0; m_phase = m_next;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(addr_as_slave, e_aas, cur_req, "model addr_as_slave");
      chk(addr_by_gc,    e_gc,  cur_req, "model addr_by_gc");
      chk(slave_rw,      e_rw,  cur_req, "model slave_rw");
      chk(ack_drive,     e_ack, cur_req, "model ack_drive");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
    idle(1);
  endtask

  task automatic do_stop();
    @(negedge clk) stop_evt = 1'b1;
    @(negedge clk) stop_evt = 1'b0;
    idle(1);
  endtask

  task automatic bit_clk(input logic b);
    @(negedge clk) sda_in = b;
    @(negedge clk) scl_rise = 1'b1;
    @(negedge clk) scl_rise = 1'b0;
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_clk(v[i]);
  endtask

  task automatic ack_slot();
    bit_clk(1'b1);
  endtask

  initial begin
    idle(3);
    chk(addr_as_slave, 1'b0, "R1", "reset addr_as_slave");
    chk(addr_by_gc,    1'b0, "R1", "reset addr_by_gc");
    chk(slave_rw,      1'b0, "R1", "reset slave_rw");
    chk(ack_drive,     1'b0, "R1", "reset ack_drive");
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R9: SCL activity before any START changes nothing
    cur_req = "R9";
    send_byte(8'hAA); ack_slot();
    chk(addr_as_slave, 1'b0, "R9", "no START, no match");

    // R2/R3: 7-bit write to own address 0x55
    cur_req = "R2";
    do_start(); send_byte(8'hAA);
    chk(addr_as_slave, 1'b1, "R2", "7-bit match");
    chk(slave_rw,      1'b0, "R2", "write direction");
    chk(ack_drive,     1'b1, "R3", "ack held after bit 8 fall");
    cur_req = "R3";
    ack_slot();
    chk(ack_drive,     1'b0, "R3", "ack released after bit 9");
    cur_req = "R8";
    do_stop();
    chk(addr_as_slave, 1'b0, "R8", "STOP clears match");

    // R2/R8: 7-bit read, then repeated START
    cur_req = "R2";
    do_start(); send_byte(8'hAB);
    chk(slave_rw,      1'b1, "R2", "read direction");
    ack_slot();
    cur_req = "R8";
    do_start();
    chk(addr_as_slave, 1'b0, "R8", "repeated START clears match");
    chk(slave_rw,      1'b1, "R8", "slave_rw kept");

    // R4: mismatch, later bytes ignored
    cur_req = "R4";
    send_byte(8'hA8);
    chk(ack_drive,     1'b0, "R4", "no ack on mismatch");
    ack_slot(); send_byte(8'hAA);
    chk(addr_as_slave, 1'b0, "R4", "later byte ignored");
    chk(ack_drive,     1'b0, "R4", "later byte not acked");
    ack_slot(); do_stop();

    // R5: general call
    cur_req = "R5";
    do_start(); send_byte(8'h00);
    chk(addr_by_gc,    1'b0, "R5", "gc disabled ignored");
    ack_slot(); do_stop();
    gc_enable = 1'b1;
    do_start(); send_byte(8'h00);
    chk(addr_by_gc,    1'b1, "R5", "gc matched");
    chk(addr_as_slave, 1'b0, "R5", "gc not own match");
    chk(ack_drive,     1'b1, "R5", "gc acked");
    ack_slot(); do_stop();
    do_start(); send_byte(8'h01);
    chk(addr_by_gc,    1'b0, "R5", "0x01 not gc");
    ack_slot(); do_stop();

    // R6: 10-bit address 0x1D5 -> 0xF2 then 0xD5
    cur_req = "R6";
    ten_bit_mode = 1'b1; own_addr = 10'h1D5;
    do_start(); send_byte(8'hF2);
    chk(ack_drive,     1'b1, "R6", "header acked");
    chk(addr_as_slave, 1'b0, "R6", "not yet addressed");
    ack_slot(); send_byte(8'hD5);
    chk(addr_as_slave, 1'b1, "R6", "10-bit match");
    chk(ack_drive,     1'b1, "R6", "low byte acked");
    chk(slave_rw,      1'b0, "R6", "header direction");
    ack_slot(); do_stop();
    do_start(); send_byte(8'hF2); ack_slot(); send_byte(8'hD4);
    chk(ack_drive,     1'b0, "R6", "low mismatch not acked");
    chk(addr_as_slave, 1'b0, "R6", "low mismatch no flag");
    ack_slot(); do_stop();

    // R7: 7-bit form ignored in 10-bit mode, gc still works
    cur_req = "R7";
    do_start(); send_byte(8'hAA);
    chk(ack_drive,     1'b0, "R7", "7-bit ignored");
    chk(addr_as_slave, 1'b0, "R7", "7-bit no flag");
    ack_slot(); do_stop();
    do_start(); send_byte(8'h00);
    chk(addr_by_gc,    1'b1, "R7", "gc in 10-bit mode");
    ack_slot(); do_stop();

    // R9: START mid-byte restarts counting
    cur_req = "R9";
    ten_bit_mode = 1'b0; gc_enable = 1'b0; own_addr = 10'h055;
    do_start(); bit_clk(1'b1); bit_clk(1'b1); bit_clk(1'b1);
    do_start(); send_byte(8'hAA);
    chk(addr_as_slave, 1'b1, "R9", "match after restart");
    ack_slot(); do_stop();

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule